// File: doc/BRIEF.md
# Memory Array Sum Accumulator

This block adds up a fixed number of words held in an external synchronous memory. A one-cycle `start` pulse launches a run. The block clears its running total and its loop index. It then walks the index from zero upward. For each step it issues one read at `base_addr + index` and adds the returned word into a wide accumulator. When the index reaches the element count, the block raises `done` and holds the total on `sum` until the next `start`.

A small state machine sequences the work through init, compare, load and accumulate states. A separate datapath holds the three registers: index, accumulator and address. Each register is loaded either with its start value or with its updated value. A parameter chooses how the additions are built. One build uses three dedicated adders. The other build routes every addition through a single shared adder, which needs one extra state per element.

Top module: `arrsum_top`

## Requirements
- R1: While reset is high and after it falls, `done` and `mem_rd` are 0 and `sum` is 0 until a run is started.
- R2: `start` begins a run from the idle state or from the finished state. A `start` pulse that arrives while a run is in progress has no effect on the result or on the timing.
- R3: Every run begins by clearing the accumulator and the index together, so a result never contains words from an earlier run.
- R4: A run issues exactly COUNT reads. Read k (k = 0 .. COUNT-1) presents `mem_addr = (base_addr + k) mod 2^ADDR_W`, and the reads come in increasing k order.
- R5: When `done` rises, `sum` equals the sum of the COUNT words, each taken as unsigned, modulo 2^ACC_W. Overflow wraps silently.
- R6: The memory returns a word on `mem_rdata` exactly one cycle after the cycle in which `mem_rd` is high, and the block uses that word.
- R7: `done` stays high, and `sum` stays unchanged, for as long as no new `start` arrives.
- R8: With the three-adder build (SHARED_ADDER=0), `done` rises 2 + 3*COUNT clock edges after the edge that samples `start`. With the shared-adder build (SHARED_ADDER=1), it rises 2 + 4*COUNT edges after that edge. Both builds produce the same sums.
- R9: `mem_rd` is never high in two consecutive cycles, and it is never high while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse that launches a run |
| base_addr | input | ADDR_W | Address of the first element |
| mem_addr | output | ADDR_W | Read address presented to the memory |
| mem_rd | output | 1 | Read strobe, one cycle per element |
| mem_rdata | input | ELEM_W | Word returned one cycle after the strobe |
| sum | output | ACC_W | Accumulated total |
| done | output | 1 | High while the run is finished |

## Verification
A stuck or skipped index shows up at once at the memory port: the next strobe carries an address other than the expected base plus k, and the total number of strobes per run differs from COUNT. An accumulator that is not cleared, or that takes the word in the wrong cycle, is not visible until `done` rises. At that point `sum` disagrees with a total computed in the bench from the memory contents. A state machine that loops too long or too briefly shows up as a `done` edge at the wrong cycle, measured against the 3 or 4 cycles per element of the selected build.

// File: rtl/arrsum_pkg.sv
package arrsum_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_CMP,
        ST_LOAD,
        ST_ACC,
        ST_INC,
        ST_DONE
    } st_e;

    // Register-load controls from the sequencer to the datapath
    typedef struct packed {
        logic clr;       // load start values into all registers
        logic addr_upd;  // address register takes base + index
        logic acc_upd;   // accumulator takes acc + word
        logic idx_upd;   // index takes index + 1
    } dp_ctl_t;

    function automatic int cycles_per_elem(input bit shared);
        return shared ? 4 : 3;
    endfunction

endpackage

// File: rtl/arrsum_ctrl.sv
module arrsum_ctrl
    import arrsum_pkg::*;
#(
    parameter bit SHARED_ADDER = 1'b0
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     more,
    output dp_ctl_t  ctl,
    output logic     mem_rd,
    output logic     done
);

    st_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    always_comb begin
        st_d   = st_q;
        ctl    = '0;
        mem_rd = 1'b0;
        done   = 1'b0;
        case (st_q)
            ST_IDLE: if (start) st_d = ST_INIT;
            ST_INIT: begin
                ctl.clr = 1'b1;
                st_d    = ST_CMP;
            end
            ST_CMP: begin
                if (more) begin
                    ctl.addr_upd = 1'b1;
                    st_d         = ST_LOAD;
                end else begin
                    st_d = ST_DONE;
                end
            end
            ST_LOAD: begin
                mem_rd = 1'b1;
                st_d   = ST_ACC;
            end
            ST_ACC: begin
                ctl.acc_upd = 1'b1;
                if (SHARED_ADDER) begin
                    st_d = ST_INC;
                end else begin
                    ctl.idx_upd = 1'b1;
                    st_d        = ST_CMP;
                end
            end
            ST_INC: begin
                ctl.idx_upd = 1'b1;
                st_d        = ST_CMP;
            end
            ST_DONE: begin
                done = 1'b1;
                if (start) st_d = ST_INIT;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd); // R9
    AST_RD_NOT_DONE: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && done)); // R9
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done); // R7

endmodule

// File: rtl/arrsum_dp.sv
module arrsum_dp
    import arrsum_pkg::*;
#(
    parameter int ADDR_W       = 10,
    parameter int ELEM_W       = 16,
    parameter int ACC_W        = 32,
    parameter int COUNT        = 128,
    parameter bit SHARED_ADDER = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  dp_ctl_t           ctl,
    input  logic              mem_rd,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ELEM_W-1:0] mem_rdata,
    output logic              more,
    output logic [ADDR_W-1:0] addr_q,
    output logic [ACC_W-1:0]  acc_q
);

    localparam int IDX_W = $clog2(COUNT + 1);
    localparam logic [IDX_W-1:0] CNT_L = IDX_W'(COUNT);

    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  idx_sum;
    logic [ADDR_W-1:0] addr_sum;
    logic [ACC_W-1:0]  acc_sum;

    generate
        if (SHARED_ADDER) begin : g_shared
            logic [ACC_W-1:0] opa, opb, res;
            always_comb begin
                if (ctl.addr_upd) begin
                    opa = ACC_W'(base_addr);
                    opb = ACC_W'(idx_q);
                end else if (ctl.acc_upd) begin
                    opa = acc_q;
                    opb = ACC_W'(mem_rdata);
                end else begin
                    opa = ACC_W'(idx_q);
                    opb = ACC_W'(1);
                end
            end
            assign res      = opa + opb;
            assign addr_sum = res[ADDR_W-1:0];
            assign idx_sum  = res[IDX_W-1:0];
            assign acc_sum  = res;
        end else begin : g_direct
            assign addr_sum = base_addr + ADDR_W'(idx_q);
            assign idx_sum  = idx_q + IDX_W'(1);
            assign acc_sum  = acc_q + ACC_W'(mem_rdata);
        end
    endgenerate

    assign more = (idx_q < CNT_L);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            acc_q  <= '0;
            addr_q <= '0;
        end else begin
            if (ctl.clr)          idx_q <= '0;
            else if (ctl.idx_upd) idx_q <= idx_sum;
            if (ctl.clr)          acc_q <= '0;
            else if (ctl.acc_upd) acc_q <= acc_sum;
            if (ctl.clr)           addr_q <= base_addr;
            else if (ctl.addr_upd) addr_q <= addr_sum;
        end
    end

    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
        idx_q <= CNT_L); // R4
    AST_RD_IN_LOOP: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> (idx_q < CNT_L)); // R4
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
        ctl.clr |=> (acc_q == '0 && idx_q == '0)); // R3

endmodule

// File: rtl/arrsum_top.sv
module arrsum_top
    import arrsum_pkg::*;
#(
    parameter int ADDR_W       = 10,
    parameter int ELEM_W       = 16,
    parameter int ACC_W        = 32,
    parameter int COUNT        = 128,
    parameter bit SHARED_ADDER = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [ELEM_W-1:0] mem_rdata,
    output logic [ACC_W-1:0]  sum,
    output logic              done
);

    dp_ctl_t ctl;
    logic    more;

    arrsum_ctrl #(.SHARED_ADDER(SHARED_ADDER)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .more   (more),
        .ctl    (ctl),
        .mem_rd (mem_rd),
        .done   (done)
    );

    arrsum_dp #(
        .ADDR_W       (ADDR_W),
        .ELEM_W       (ELEM_W),
        .ACC_W        (ACC_W),
        .COUNT        (COUNT),
        .SHARED_ADDER (SHARED_ADDER)
    ) u_dp (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .mem_rd    (mem_rd),
        .base_addr (base_addr),
        .mem_rdata (mem_rdata),
        .more      (more),
        .addr_q    (mem_addr),
        .acc_q     (sum)
    );

    AST_SUM_HELD: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> $stable(sum)); // R7

endmodule

// File: tb/sim_arrsum_top.sv
module sim_arrsum_top;

    localparam int AW = 10;
    localparam int MEMSZ = 1 << AW;
    localparam int N0 = 128;
    localparam int N1 = 20;
    localparam int W1 = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [15:0] mem [MEMSZ];

    logic          start0 = 1'b0, start1 = 1'b0;
    logic [AW-1:0] base0 = '0, base1 = '0;
    logic [AW-1:0] addr0, addr1;
    logic          rd0, rd1, done0, done1;
    logic [15:0]   rdata0 = '0, rdata1 = '0;
    logic [31:0]   sum0;
    logic [W1-1:0] sum1;

    arrsum_top u0 (
        .clk(clk), .rst(rst), .start(start0), .base_addr(base0),
        .mem_addr(addr0), .mem_rd(rd0), .mem_rdata(rdata0),
        .sum(sum0), .done(done0)
    );

    arrsum_top #(.ACC_W(W1), .COUNT(N1), .SHARED_ADDER(1'b1)) u1 (
        .clk(clk), .rst(rst), .start(start1), .base_addr(base1),
        .mem_addr(addr1), .mem_rd(rd1), .mem_rdata(rdata1),
        .sum(sum1), .done(done1)
    );

    // memory models: word valid one cycle after the strobe
    always @(posedge clk) begin
        if (rd0) rdata0 <= mem[addr0];
        if (rd1) rdata1 <= mem[addr1];
    end

    int nchk = 0, nfail = 0;
    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // scoreboard state
    longint sq0[$], lq0[$], sq1[$], lq1[$];
    longint t0_0 = 0, t0_1 = 0;
    int exp_a0 = 0, exp_a1 = 0, nrd0 = 0, nrd1 = 0;
    bit pdone0 = 0, pdone1 = 0, prd0 = 0, prd1 = 0;

    // monitor: reads and results, sampled at the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            if (rd0) begin
                chk(addr0 == AW'(exp_a0), "R4 addr u0", addr0, exp_a0 % MEMSZ);
                chk(!prd0, "R9 back-to-back strobe u0", 1, 0);
                exp_a0++; nrd0++;
            end
            if (rd1) begin
                chk(addr1 == AW'(exp_a1), "R4 addr u1", addr1, exp_a1 % MEMSZ);
                chk(!prd1, "R9 back-to-back strobe u1", 1, 0);
                exp_a1++; nrd1++;
            end
            if (done0 && !pdone0) begin
                longint es, el;
                es = sq0.pop_front(); el = lq0.pop_front();
                chk(sum0 == 32'(es), "R5 sum u0", sum0, es);
                chk(cyc - t0_0 == el, "R8 latency u0", cyc - t0_0, el);
                chk(nrd0 == N0, "R4 read count u0", nrd0, N0);
                nrd0 = 0;
            end
            if (done1 && !pdone1) begin
                longint es, el;
                es = sq1.pop_front(); el = lq1.pop_front();
                chk(sum1 == W1'(es), "R5 R8 sum u1", sum1, es);
                chk(cyc - t0_1 == el, "R8 latency u1", cyc - t0_1, el);
                chk(nrd1 == N1, "R4 read count u1", nrd1, N1);
                nrd1 = 0;
            end
        end
        pdone0 = done0; pdone1 = done1;
        prd0 = rd0; prd1 = rd1;
    end

    // driver: pushes the expected result, then launches the run
    task automatic run(input int inst, input int base, input bit busy_pulse);
        int n, step, aw;
        longint s;
        n    = inst ? N1 : N0;
        step = inst ? 4 : 3;
        aw   = inst ? W1 : 32;
        s    = 0;
        for (int k = 0; k < n; k++) s += longint'(mem[(base + k) % MEMSZ]);
        s = s % (longint'(1) << aw);
        @(negedge clk);
        if (inst == 0) begin
            sq0.push_back(s); lq0.push_back(3 + step * n);
            base0 = AW'(base); exp_a0 = base; start0 = 1'b1; t0_0 = cyc;
        end else begin
            sq1.push_back(s); lq1.push_back(3 + step * n);
            base1 = AW'(base); exp_a1 = base; start1 = 1'b1; t0_1 = cyc;
        end
        @(negedge clk);
        start0 = 1'b0; start1 = 1'b0;
        if (busy_pulse) begin
            repeat (10) @(negedge clk);
            if (inst == 0) start0 = 1'b1; else start1 = 1'b1;
            @(negedge clk);
            start0 = 1'b0; start1 = 1'b0;
        end
        while (!(inst ? done1 : done0)) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < MEMSZ; i++) mem[i] = 16'((i * 37 + 5) ^ (i << 7));
        for (int i = 600; i < 728; i++) mem[i] = 16'hFFFF;
        repeat (3) @(negedge clk);
        chk(done0 == 0 && done1 == 0, "R1 done in reset", done0, 0);
        chk(rd0 == 0 && rd1 == 0, "R1 strobe in reset", rd0, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(sum0 == 0, "R1 sum after reset", sum0, 0);
        chk(done0 == 0 && rd0 == 0, "R1 idle after reset", done0, 0);

        run(0, 0, 0);
        begin
            logic [31:0] held;
            held = sum0;
            repeat (6) @(negedge clk);
            chk(done0 == 1, "R7 done held", done0, 1);
            chk(sum0 == held, "R7 sum held", sum0, held);
        end
        run(0, 600, 0);                       // R3 R6 restart clears, all-ones words
        chk(sum0 == 32'd8388480, "R3 R5 all-ones total", sum0, 8388480);
        run(0, 1000, 0);                      // R4 address wrap
        run(0, 50, 1);                        // R2 start while busy ignored
        run(1, 600, 0);                       // R5 R8 wrap in narrow accumulator
        chk(sum1 == W1'(262124), "R5 wrap value", sum1, 262124);
        run(1, 5, 1);                         // R2 R8 shared build busy start
        chk(sq0.size() == 0 && sq1.size() == 0, "R2 no extra results", sq0.size() + sq1.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        wait (cyc > 100000);
        chk(0, "watchdog", cyc, 100000);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule